// File: doc/BRIEF.md
# Texture Memory Block Loader

The loader moves a contiguous run of texels from a system-memory read port into a 4096-byte texture memory built from 64-bit words. A single command carries a source byte address, the index of the last texel, a texel size code, a destination word offset and an unsigned line-advance value. The advance value has 1 integer bit and 11 fraction bits. From these the block works out how many 64-bit words to move. It fetches them one by one and writes each one through the texture-memory write port.

When the advance value is nonzero, the block divides the run into lines of ceil(2048 / advance) words. It rearranges the data on every second line, so that a sampler reading later can fetch neighbouring texels from different banks in the same cycle. An iterative divider finds the line length before the first fetch. Before any access, the block checks the command against the top of system memory and the top of texture memory. A command that would run past either limit is dropped and flagged.

Top module: `tmem_block_loader`

## Requirements
- R1: After reset, busy_o, done_o, err_o, mem_req_o and tmem_we_o are all low.
- R2: The size code 0/1/2/3 selects 4/8/16/32 bits per texel. The byte count is ((cmd_last_i + 1) << cmd_size_i) >> 1, and exactly ceil(bytes / 8) words are written. A command with zero bytes raises done_o in the cycle after acceptance, with no read and no write.
- R3: The k-th read request of a command carries address cmd_addr_i + 8k. mem_req_o is a one-cycle pulse, and no new request is issued until the previous data has returned.
- R4: Every write lands at cmd_ofs_i plus the word's position. cmd_ofs_i counts 64-bit words, so its byte offset is cmd_ofs_i * 8. No location is written twice.
- R5: With an advance value of 0, word k is written unchanged to offset + k.
- R6: With a nonzero advance value A, the run is split into lines of L = ceil(2048 / A) words. Each line takes min(L, remaining words). Line 0 is even and lines alternate after it. Even lines are written unchanged.
- R7: On odd lines with size codes 0 to 2, bits [63:32] and [31:0] of each word are exchanged.
- R8: On odd lines with size code 3, the word at line position j is written to position j^1 with its data unchanged. A final word with no partner inside the line stays at its own position.
- R9: A command is dropped if cmd_addr_i + bytes exceeds the system memory size, or if cmd_ofs_i * 8 + bytes exceeds 4096. A dropped command issues no read and no write. err_o and done_o are high in the cycle after acceptance. err_o stays high until the next command is accepted.
- R10: A command is accepted only while busy_o is low. busy_o is high from the cycle after acceptance until the last write. done_o pulses for one cycle, while busy_o is low, right after the last write. Commands presented while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present; taken when busy_o is low |
| cmd_addr_i | input | ADDR_W | Source byte address, 8-byte aligned |
| cmd_last_i | input | IDX_W | Index of the last texel |
| cmd_size_i | input | 2 | Texel size code |
| cmd_ofs_i | input | OFS_W | Destination offset in 64-bit words |
| cmd_adv_i | input | FRAC_W+1 | Line-advance value, 1.11 unsigned fixed point |
| mem_req_o | output | 1 | Read request pulse |
| mem_addr_o | output | ADDR_W | Read byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |
| tmem_we_o | output | 1 | Texture-memory write enable |
| tmem_waddr_o | output | OFS_W | Texture-memory word address |
| tmem_wdata_o | output | 64 | Texture-memory write data |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last accepted command was dropped |

## Verification
Faults in the line counters show up at the ports as soon as the first line boundary passes. With advance values that give lines of one to seven words, a wrong line length, parity or partner position moves a write address or swaps data within a few beats. A divider fault lengthens or shortens every line, so it corrupts the map of written locations for that command. A fault in the word counter or the bounds logic shows up as an extra or missing read, or as a write after a drop. Each command is compared against a full 512-word expected image before the next one starts.

// File: rtl/tmem_ldr_pkg.sv
package tmem_ldr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_DIV,
    ST_REQ,
    ST_WAIT
  } ld_state_e;

  localparam logic [1:0] SIZE_32B = 2'd3;
  localparam int WORD_W = 64;
endpackage

// File: rtl/tmem_ldr_div.sv
module tmem_ldr_div #(
  parameter int NUM_W = 13,
  parameter int DEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] num_q, quo_q;
  logic [DEN_W-1:0] den_q;
  logic [DEN_W:0]   rem_q, rem_sh;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q, ge;

  assign rem_sh = {rem_q[DEN_W-1:0], num_q[NUM_W-1]};
  assign ge     = rem_sh >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      num_q  <= num_i;
      den_q  <= den_i;
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= CNT_W'(NUM_W - 1);
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (run_q) begin
      rem_q <= ge ? (rem_sh - {1'b0, den_q}) : rem_sh;
      quo_q <= {quo_q[NUM_W-2:0], ge};
      num_q <= num_q << 1;
      if (cnt_q == '0) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
endmodule

// File: rtl/tmem_ldr_seq.sv
module tmem_ldr_seq #(
  parameter int WCNT_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WCNT_W-1:0] words_i,
  input  logic [WCNT_W-1:0] wpl_i,
  input  logic              reorder_i,
  input  logic              pair_i,
  input  logic              step_i,
  output logic [WCNT_W-1:0] src_idx_o,
  output logic [WCNT_W-1:0] dst_rel_o,
  output logic              odd_o,
  output logic              last_o
);
  logic [WCNT_W-1:0] words_q, k_q, j_q, lstart_q, len_q;
  logic [WCNT_W-1:0] k_nxt, rem_nxt, jx, pos;
  logic              odd_q;

  function automatic logic [WCNT_W-1:0] min_w(input logic [WCNT_W-1:0] a,
                                               input logic [WCNT_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  assign k_nxt   = k_q + 1'b1;
  assign rem_nxt = words_q - k_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      words_q  <= '0;
      k_q      <= '0;
      j_q      <= '0;
      lstart_q <= '0;
      len_q    <= '0;
      odd_q    <= 1'b0;
    end else if (start_i) begin
      words_q  <= words_i;
      k_q      <= '0;
      j_q      <= '0;
      lstart_q <= '0;
      len_q    <= min_w(wpl_i, words_i);
      odd_q    <= 1'b0;
    end else if (step_i) begin
      k_q <= k_nxt;
      if (j_q + 1'b1 == len_q) begin
        j_q      <= '0;
        lstart_q <= k_nxt;
        odd_q    <= odd_q ^ reorder_i;
        len_q    <= min_w(wpl_i, rem_nxt);
      end else begin
        j_q <= j_q + 1'b1;
      end
    end
  end

  // partner of j inside the current line, if it exists
  assign jx  = j_q ^ WCNT_W'(1);
  assign pos = (pair_i && odd_q && (jx < len_q)) ? jx : j_q;

  assign src_idx_o = k_q;
  assign dst_rel_o = lstart_q + pos;
  assign odd_o     = odd_q;
  assign last_o    = (k_nxt == words_q);
endmodule

// File: rtl/tmem_ldr_swap.sv
module tmem_ldr_swap #(
  parameter int WORD_W = 64
) (
  input  logic [WORD_W-1:0] data_i,
  input  logic              half_swap_i,
  output logic [WORD_W-1:0] data_o
);
  localparam int HALF = WORD_W / 2;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign data_o[g*HALF +: HALF] = half_swap_i ? data_i[(1-g)*HALF +: HALF]
                                                : data_i[g*HALF +: HALF];
  end
endmodule

// File: rtl/tmem_block_loader.sv
module tmem_block_loader
  import tmem_ldr_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int SYS_BYTES  = 1 << 20,
  parameter int TMEM_BYTES = 4096,
  parameter int IDX_W      = 12,
  parameter int FRAC_W     = 11,
  localparam int OFS_W     = $clog2(TMEM_BYTES / 8),
  localparam int ADV_W     = FRAC_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [IDX_W-1:0]  cmd_last_i,
  input  logic [1:0]        cmd_size_i,
  input  logic [OFS_W-1:0]  cmd_ofs_i,
  input  logic [ADV_W-1:0]  cmd_adv_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [63:0]       mem_rdata_i,
  output logic              tmem_we_o,
  output logic [OFS_W-1:0]  tmem_waddr_o,
  output logic [63:0]       tmem_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int NUM_W   = ADV_W + 1;
  localparam int BYTES_W = IDX_W + 3;
  localparam int WCNT_W  = BYTES_W - 2;
  localparam int EXT_W   = ((ADDR_W > BYTES_W) ? ADDR_W : BYTES_W) + 2;
  localparam int DST_W   = ((OFS_W + 3 > BYTES_W) ? OFS_W + 3 : BYTES_W) + 1;

  ld_state_e state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [1:0]        size_q;
  logic [ADV_W-1:0]  adv_q;
  logic [WCNT_W-1:0] words_q;
  logic              done_q, err_q;

  // command sizing and bounds
  logic [IDX_W:0]    cnt;
  logic [IDX_W+3:0]  shifted;
  logic [BYTES_W-1:0] bytes;
  logic [BYTES_W:0]  bytes_rnd;
  logic [WCNT_W-1:0] words;
  logic [EXT_W-1:0]  src_end;
  logic [DST_W-1:0]  dst_end;
  logic              src_bad, dst_bad, cmd_bad, accept;

  assign cnt       = (IDX_W+1)'(cmd_last_i) + 1'b1;
  assign shifted   = (IDX_W+4)'(cnt) << cmd_size_i;
  assign bytes     = shifted[IDX_W+3:1];
  assign bytes_rnd = {1'b0, bytes} + (BYTES_W+1)'(7);
  assign words     = WCNT_W'(bytes_rnd >> 3);
  assign src_end   = EXT_W'(cmd_addr_i) + EXT_W'(bytes);
  assign dst_end   = DST_W'({cmd_ofs_i, 3'b000}) + DST_W'(bytes);
  assign src_bad   = src_end > EXT_W'(SYS_BYTES);
  assign dst_bad   = dst_end > DST_W'(TMEM_BYTES);
  assign cmd_bad   = src_bad || dst_bad;
  assign accept    = cmd_valid_i && (state_q == ST_IDLE);

  // sub-block hookup
  logic              div_start, div_done;
  logic [NUM_W-1:0]  div_num, div_quo;
  logic              seq_start, seq_step, seq_odd, seq_last;
  logic [WCNT_W-1:0] wpl, src_idx, dst_rel;

  assign div_start = (state_q == ST_PREP) && (adv_q != '0);
  assign div_num   = NUM_W'((1 << FRAC_W) - 1) + NUM_W'(adv_q);
  assign seq_start = ((state_q == ST_PREP) && (adv_q == '0)) ||
                     ((state_q == ST_DIV) && div_done);
  assign seq_step  = (state_q == ST_WAIT) && mem_rvalid_i;
  assign wpl       = (adv_q == '0) ? '1 : WCNT_W'(div_quo);

  tmem_ldr_div #(
    .NUM_W(NUM_W),
    .DEN_W(ADV_W)
  ) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_start),
    .num_i  (div_num),
    .den_i  (adv_q),
    .done_o (div_done),
    .quo_o  (div_quo)
  );

  tmem_ldr_seq #(
    .WCNT_W(WCNT_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (seq_start),
    .words_i  (words_q),
    .wpl_i    (wpl),
    .reorder_i(adv_q != '0),
    .pair_i   (size_q == SIZE_32B),
    .step_i   (seq_step),
    .src_idx_o(src_idx),
    .dst_rel_o(dst_rel),
    .odd_o    (seq_odd),
    .last_o   (seq_last)
  );

  tmem_ldr_swap #(
    .WORD_W(WORD_W)
  ) u_swap (
    .data_i     (mem_rdata_i),
    .half_swap_i(seq_odd && (size_q != SIZE_32B)),
    .data_o     (tmem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      ofs_q   <= '0;
      size_q  <= '0;
      adv_q   <= '0;
      words_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            err_q <= cmd_bad;
            if (cmd_bad || (words == '0)) begin
              done_q <= 1'b1;
            end else begin
              addr_q  <= cmd_addr_i;
              ofs_q   <= cmd_ofs_i;
              size_q  <= cmd_size_i;
              adv_q   <= cmd_adv_i;
              words_q <= words;
              state_q <= ST_PREP;
            end
          end
        end
        ST_PREP: state_q <= (adv_q == '0) ? ST_REQ : ST_DIV;
        ST_DIV:  if (div_done) state_q <= ST_REQ;
        ST_REQ:  state_q <= ST_WAIT;
        ST_WAIT: begin
          if (mem_rvalid_i) begin
            if (seq_last) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_REQ;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o    = (state_q == ST_REQ);
  assign mem_addr_o   = addr_q + ADDR_W'({src_idx, 3'b000});
  assign tmem_we_o    = seq_step;
  assign tmem_waddr_o = ofs_q + OFS_W'(dst_rel);
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign err_o        = err_q;
endmodule

// File: rtl/tmem_ldr_chk.sv
module tmem_ldr_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mem_req_o,
  input logic tmem_we_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);
  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_one_outstanding_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  assert_req_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  assert_write_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmem_we_o |-> busy_o);

  assert_err_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (done_o && !busy_o));

  assert_err_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !tmem_we_o);
endmodule

bind tmem_block_loader tmem_ldr_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mem_req_o(mem_req_o),
  .tmem_we_o(tmem_we_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o)
);

// File: tb/tb_tmem_block_loader.sv
`timescale 1ns/1ps
module tb_tmem_block_loader;
  localparam int ADDR_W = 20;
  localparam int SYS_BYTES = 1 << 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [19:0] cmd_addr = '0;
  logic [11:0] cmd_last = '0;
  logic [1:0]  cmd_size = '0;
  logic [8:0]  cmd_ofs = '0;
  logic [11:0] cmd_adv = '0;
  logic        mem_req, mem_rvalid, tmem_we, busy, done, err;
  logic [19:0] mem_addr;
  logic [63:0] mem_rdata, tmem_wdata;
  logic [8:0]  tmem_waddr;

  always #4 clk = ~clk;

  tmem_block_loader dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_addr_i(cmd_addr), .cmd_last_i(cmd_last),
    .cmd_size_i(cmd_size), .cmd_ofs_i(cmd_ofs), .cmd_adv_i(cmd_adv),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .tmem_we_o(tmem_we), .tmem_waddr_o(tmem_waddr), .tmem_wdata_o(tmem_wdata),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  int checks = 0;
  int errors = 0;

  function automatic logic [63:0] mw(input int a);
    return {32'(a) ^ 32'h5a5a0000, 32'(a * 3 + 17)};
  endfunction

  // memory model with variable latency
  logic pend;
  int   lat, paddr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; lat <= 0; paddr <= 0; mem_rvalid <= 1'b0; mem_rdata <= '0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_req) begin
        pend  <= 1'b1;
        paddr <= int'(mem_addr);
        lat   <= (int'(mem_addr) >> 3) % 3;
      end else if (pend) begin
        if (lat == 0) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mw(paddr);
          pend       <= 1'b0;
        end else lat <= lat - 1;
      end
    end
  end

  logic [63:0] exp_data [512];
  bit          exp_set  [512];
  logic [63:0] got_data [512];
  bit          got_set  [512];
  int wr_cnt, rd_cnt, rd_bad, dup, rd_base;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) begin
        if (int'(mem_addr) != rd_base + 8 * rd_cnt) rd_bad++;
        rd_cnt++;
      end
      if (tmem_we) begin
        if (got_set[tmem_waddr]) dup++;
        got_set[tmem_waddr]  = 1'b1;
        got_data[tmem_waddr] = tmem_wdata;
        wr_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic run_cmd(input int addr, input int last, input int size,
                         input int ofs, input int adv, input bit bad);
    int bytes, w, l, lstart, n, j, clen, pos, dst, mism, first, t;
    logic [63:0] d;
    string tag;
    bytes = ((last + 1) << size) >> 1;
    w = (bytes + 7) / 8;
    l = (adv != 0) ? (2048 + adv - 1) / adv : w;
    for (int i = 0; i < 512; i++) begin
      exp_set[i] = 1'b0; got_set[i] = 1'b0; exp_data[i] = '0; got_data[i] = '0;
    end
    lstart = 0; n = 0; j = 0;
    for (int k = 0; k < w; k++) begin
      clen = (w - lstart < l) ? w - lstart : l;
      d = mw(addr + 8 * k);
      pos = j;
      if (adv != 0 && n % 2 == 1) begin
        if (size == 3) begin
          if ((j ^ 1) < clen) pos = j ^ 1;
        end else d = {d[31:0], d[63:32]};
      end
      dst = ofs + lstart + pos;
      exp_set[dst] = 1'b1; exp_data[dst] = d;
      j++;
      if (j == clen) begin j = 0; lstart = k + 1; n++; end
    end
    wr_cnt = 0; rd_cnt = 0; rd_bad = 0; dup = 0; rd_base = addr;
    tag = (adv == 0) ? "R5 R4" : (size == 3) ? "R8 R6" : "R7 R6";

    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = 20'(addr); cmd_last = 12'(last);
    cmd_size = 2'(size); cmd_ofs = 9'(ofs); cmd_adv = 12'(adv);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (bad) begin
      chk(err && done && !busy, "R9", "drop flags err/done/busy", {err, done, busy}, 3'b110);
      repeat (6) @(negedge clk);
      chk(rd_cnt == 0 && wr_cnt == 0, "R9", "accesses after drop", rd_cnt + wr_cnt, 0);
      chk(err, "R9", "err held", err, 1);
    end else if (w == 0) begin
      chk(done && !busy && !err, "R2", "zero-byte done/busy/err", {done, busy, err}, 3'b100);
      repeat (3) @(negedge clk);
      chk(rd_cnt == 0 && wr_cnt == 0, "R2", "zero-byte accesses", rd_cnt + wr_cnt, 0);
    end else begin
      chk(busy && !err && !done, "R10", "busy after accept", {busy, err, done}, 3'b100);
      // command while busy must be ignored
      cmd_valid = 1'b1; cmd_addr = 20'h100; cmd_last = 12'd5; cmd_ofs = 9'd0;
      cmd_adv = 12'd0; cmd_size = 2'd1;
      @(negedge clk);
      cmd_valid = 1'b0;
      t = 0;
      while (!done && t < 20000) begin @(negedge clk); t++; end
      chk(done && !busy, "R10", "done pulse with busy low", {done, busy}, 2'b10);
      @(negedge clk);
      chk(!done, "R10", "done is one cycle", done, 0);
      chk(wr_cnt == w && dup == 0, "R2", "write count", wr_cnt, w);
      chk(rd_cnt == w && rd_bad == 0, "R3", "read count/sequence", rd_cnt, w);
      mism = 0; first = -1;
      for (int i = 0; i < 512; i++)
        if (got_set[i] != exp_set[i] || (exp_set[i] && got_data[i] != exp_data[i])) begin
          mism++;
          if (first < 0) first = i;
        end
      if (first < 0) chk(1'b1, tag, "image", 0, 0);
      else chk(1'b0, tag, $sformatf("image word %0d", first),
               longint'(got_data[first]), longint'(exp_data[first]));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int advs[8];
    int lasts[3];
    int idx;
    advs = '{0, 4095, 2048, 1024, 700, 512, 300, 1};
    lasts = '{0, 13, 40};
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !mem_req && !tmem_we, "R1", "reset outputs",
        {busy, done, err, mem_req, tmem_we}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !err && !mem_req && !tmem_we, "R1", "idle after reset",
        {busy, done, err, mem_req, tmem_we}, 0);
    idx = 0;
    for (int a = 0; a < 8; a++)
      for (int s = 0; s < 4; s++)
        for (int l = 0; l < 3; l++) begin
          run_cmd(4096 + idx * 256, lasts[l], s, (idx * 37) % 400, advs[a], 1'b0);
          idx++;
        end
    // bounds: destination edge
    run_cmd(512, 7, 2, 511, 1024, 1'b1);
    run_cmd(512, 7, 2, 510, 1024, 1'b0);
    // bounds: source edge
    run_cmd(SYS_BYTES - 8, 7, 2, 0, 0, 1'b1);
    run_cmd(SYS_BYTES - 16, 7, 2, 0, 0, 1'b0);
    // odd-length 32-bit run with 3-word lines
    run_cmd(8192, 20, 3, 100, 700, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule